// File: doc/BRIEF.md
# Precharged Bit-Line Row Memory Sequencer

This block sequences whole-row accesses to a memory array whose columns are complementary bit-line pairs. The true line of a pair carries the bit and the other line carries its inverse. A read or a refresh always runs three timed phases. First, an active-low strobe charges both lines of every pair high. Next, one word line is raised so the selected cells discharge one line of each pair. Last, a sense phase resolves every pair to full levels and writes the sensed value back into the cells. A write raises the word line while the pairs are driven to opposite values from the write data. Every access covers a whole row.

The array is a cycle-based model of charge-storage cells. A row that is neither written nor sensed within a retention window loses its contents. An internal scheduler therefore raises a refresh request at a fixed interval and walks through the rows in ascending order, and each refresh reuses the read sequence. Users issue accesses through a request/ready handshake that carries a row number, a write flag and the write data. Read data comes back with a one-cycle valid pulse.

Top module: `bitline_mem_seq`

## Requirements
- R1: After reset, ready is 1, the precharge strobe pre_n is 1, row_sel and sense_en are 0, rd_valid is 0, and cell_err and decay_err are 0.
- R2: An access is accepted on a rising edge where req and ready are both 1. Ready is 1 only while the sequencer is idle with no refresh pending, and it is 0 in the cycle after an accept.
- R3: After a read is accepted, pre_n is 0 for PHASE_CYC cycles with row_sel all-zero. The word line then stays raised for 2*PHASE_CYC cycles, with sense_en 1 only in the last PHASE_CYC of them. Precharge never overlaps a raised word line, and at most one bit of row_sel is 1 (bit r selects row r).
- R4: rd_valid is a one-cycle pulse seen in the cycle that starts 3*PHASE_CYC clock edges after the accepting edge. During that pulse rd_data bit c holds column c of the addressed row as last written.
- R5: A write raises row_sel for exactly PHASE_CYC cycles without precharge and stores all of req_wdata into the row. It produces no rd_valid.
- R6: Raising a word line during a read or refresh while both lines of a pair are low clears that cell and sets the sticky cell_err. The sequencer never causes this, so cell_err stays 0 under any access pattern.
- R7: Every REF_INTERVAL cycles a refresh becomes pending. It runs the read sequence with ref_active high and no rd_valid. Successive refreshes select rows 0, 1, 2, … in order and wrap to 0 after ROWS-1. A pending refresh is started before a waiting user request, so a request held high cannot starve refresh.
- R8: A row that has been written and is then neither written nor sensed for RETAIN_LIM consecutive cycles reads back as all zeros afterwards and sets the sticky decay_err. Rows never written do not age.
- R9: Sensing writes the sensed value back and restarts the row's retention window, so repeated reads and refreshes leave the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | RW | Row number |
| req_wdata | input | COLS | Write data, bit c to column c |
| ready | output | 1 | Request may be accepted this cycle |
| rd_valid | output | 1 | One-cycle read-data-valid pulse |
| rd_data | output | COLS | Sensed row data |
| pre_n | output | 1 | Active-low bit-line precharge strobe |
| row_sel | output | ROWS | One-hot word line select |
| sense_en | output | 1 | Sense amplifier enable |
| ref_active | output | 1 | Current sequence is a refresh |
| cell_err | output | 1 | Sticky: cell disturbed by select on discharged lines |
| decay_err | output | 1 | Sticky: a row lost its data by retention timeout |

## Verification
Several properties are checked on every clock edge: precharge and word line never overlap, the word line is one-hot, every read-type selection follows directly after a precharge cycle, sense occurs only under a raised word line, no selection happens while a pair is fully discharged, ready falls after an accept, and the decay flag never clears. Other behaviour can only be shown by the directed scenarios: the phase lengths, the exact read latency, the returned data against a shadow copy, the ascending refresh order, the refresh priority over a request held high, restore on sensing, and data loss once a row's retention window runs out.

// File: rtl/blm_pkg.sv
// Shared types for the precharged bit-line memory sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package blm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_SEL   = 3'd2,
        ST_SENSE = 3'd3,
        ST_WR    = 3'd4
    } seq_state_e;
endpackage

// File: rtl/blm_refresh_sched.sv
// Refresh scheduler: raises a pending refresh every REF_INTERVAL cycles
// and keeps the pointer to the next row to refresh, stepping in ascending
// order with wrap-around.
// Assumes: take is high for one cycle when the sequencer starts a refresh.
module blm_refresh_sched #(
    parameter int ROWS         = 8,
    parameter int REF_INTERVAL = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   take,
    output logic                                   pend,
    output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int TW = $clog2(REF_INTERVAL + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(REF_INTERVAL - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = (tmr == TMR_LAST);

    // Interval timer: free-running modulo REF_INTERVAL.
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr <= '0;
        else if (tick) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    // Pending flag: a new tick wins over a simultaneous take.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (tick)  pend <= 1'b1;
        else if (take)  pend <= 1'b0;
    end

    // Row pointer: advance once per started refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (take) row <= (row == ROW_LAST) ? '0 : row + 1'b1;
    end

    AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend) else $error("refresh taken while none pending"); // R7
endmodule

// File: rtl/blm_sequencer.sv
// Access sequencer: accepts user requests, gives a pending refresh priority
// at the idle boundary, and drives the precharge, word line, sense and
// write-drive strobes, each phase lasting PHASE_CYC cycles.
// Assumes: the refresh scheduler holds ref_pend until ref_take.
module blm_sequencer
    import blm_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 8,
    parameter int PHASE_CYC = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req,
    input  logic                                   req_we,
    input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] req_row,
    input  logic [COLS-1:0]                        req_wdata,
    input  logic                                   ref_pend,
    input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] ref_row,
    output logic                                   ref_take,
    output logic                                   ready,
    output logic                                   pre_n,
    output logic [ROWS-1:0]                        row_sel,
    output logic                                   sense_en,
    output logic                                   wr_drive,
    output logic [COLS-1:0]                        wd,
    output logic                                   ref_active,
    output logic                                   rd_valid
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

    seq_state_e     st;
    logic [CW-1:0]  cnt;
    logic [RW-1:0]  row_q;
    logic           is_ref;
    logic           last;
    logic           sel_phase;

    assign last      = (cnt == CNT_LAST);
    assign ready     = (st == ST_IDLE) && !ref_pend;
    assign ref_take  = (st == ST_IDLE) && ref_pend;
    assign pre_n     = (st != ST_PRE);
    assign sense_en  = (st == ST_SENSE);
    assign wr_drive  = (st == ST_WR);
    assign sel_phase = (st == ST_SEL) || (st == ST_SENSE) || (st == ST_WR);
    assign ref_active = is_ref && (st != ST_IDLE);

    // Word line decode: one line per row, raised during select/sense/write.
    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        assign row_sel[r] = sel_phase && (row_q == RW'(r));
    end

    // Phase state machine with per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            row_q    <= '0;
            wd       <= '0;
            is_ref   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (ref_pend) begin
                        st     <= ST_PRE;
                        row_q  <= ref_row;
                        is_ref <= 1'b1;
                    end else if (req) begin
                        st     <= req_we ? ST_WR : ST_PRE;
                        row_q  <= req_row;
                        wd     <= req_wdata;
                        is_ref <= 1'b0;
                    end
                end
                ST_PRE: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= ST_SEL;
                end
                ST_SEL: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= ST_SENSE;
                end
                ST_SENSE: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) begin
                        st       <= ST_IDLE;
                        rd_valid <= !is_ref;
                    end
                end
                ST_WR: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready) else $error("ready held after accept"); // R2
    AST_RDV_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(sense_en)) else $error("rd_valid without sense"); // R4
    AST_REF_NO_RDV: assert property (@(posedge clk) disable iff (!rst_n)
        ref_active |=> !rd_valid || !$past(is_ref)) else $error("refresh produced rd_valid"); // R7
endmodule

// File: rtl/blm_array_model.sv
// Cycle-based array model: each column is a true/complement bit-line pair,
// each row a set of charge-storage cells with a retention counter.
// Precharge pulls both lines high, a raised word line lets each cell
// discharge one line, sense latches the true line and restores the row,
// and a write drives the pair from the write data.
// Assumes: row_sel is at most one-hot.
module blm_array_model #(
    parameter int ROWS       = 8,
    parameter int COLS       = 8,
    parameter int RETAIN_LIM = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pre_n,
    input  logic [ROWS-1:0] row_sel,
    input  logic            sense_en,
    input  logic            wr_drive,
    input  logic [COLS-1:0] wd,
    output logic [COLS-1:0] sa_out,
    output logic            cell_err,
    output logic            decay_err
);
    localparam int AW = $clog2(RETAIN_LIM + 1);
    localparam logic [AW-1:0] AGE_LAST = AW'(RETAIN_LIM - 1);

    logic [COLS-1:0] mem   [ROWS];
    logic [AW-1:0]   age   [ROWS];
    logic [ROWS-1:0] valid;
    logic [COLS-1:0] bl_t, bl_c;
    logic [COLS-1:0] cell_q;
    logic [COLS-1:0] both_low;
    logic            any_sel;
    logic            rd_sel;

    assign any_sel  = |row_sel;
    assign rd_sel   = any_sel && !wr_drive;
    assign both_low = ~bl_t & ~bl_c;

    // Cell read mux: contents of the selected row.
    always_comb begin
        cell_q = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_sel[r]) cell_q = cell_q | mem[r];
        end
    end

    // Bit-line pairs: precharge, drive, cell discharge, else bleed low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_t <= '0;
            bl_c <= '0;
        end else if (!pre_n) begin
            bl_t <= '1;
            bl_c <= '1;
        end else if (wr_drive) begin
            bl_t <= wd;
            bl_c <= ~wd;
        end else if (any_sel) begin
            bl_t <= bl_t & cell_q & ~both_low;
            bl_c <= bl_c & ~cell_q & ~both_low;
        end else begin
            bl_t <= '0;
            bl_c <= '0;
        end
    end

    // Sense latch: captures the true lines while sense is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        sa_out <= '0;
        else if (sense_en) sa_out <= bl_t;
    end

    // Cell storage, retention ageing and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= '0;
                age[r] <= '0;
            end
            valid     <= '0;
            cell_err  <= 1'b0;
            decay_err <= 1'b0;
        end else begin
            if (rd_sel && (|both_low)) cell_err <= 1'b1;
            for (int r = 0; r < ROWS; r++) begin
                if (row_sel[r] && wr_drive) begin
                    mem[r]   <= wd;
                    age[r]   <= '0;
                    valid[r] <= 1'b1;
                end else if (row_sel[r] && sense_en) begin
                    mem[r] <= bl_t;
                    age[r] <= '0;
                end else if (row_sel[r]) begin
                    mem[r] <= mem[r] & ~both_low;
                end else if (valid[r]) begin
                    if (age[r] == AGE_LAST) begin
                        mem[r]    <= '0;
                        age[r]    <= '0;
                        valid[r]  <= 1'b0;
                        decay_err <= 1'b1;
                    end else begin
                        age[r] <= age[r] + 1'b1;
                    end
                end
            end
        end
    end

    AST_PRE_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pre_n && any_sel)) else $error("precharge overlaps word line"); // R3
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel)) else $error("multiple word lines raised"); // R3
    AST_SEL_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(any_sel) && !wr_drive) |-> $past(!pre_n)) else $error("read select without precharge"); // R3
    AST_SENSE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |-> any_sel) else $error("sense without word line"); // R3
    AST_NO_DISCHARGED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (both_low == '0)) else $error("row selected on discharged pair"); // R6
    AST_DECAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        decay_err |=> decay_err) else $error("decay flag cleared"); // R8
endmodule

// File: rtl/bitline_mem_seq.sv
// Top level: refresh scheduler, access sequencer and bit-line array model.
// Assumes: synchronous active-low reset; requests held until accepted.
module bitline_mem_seq #(
    parameter int ROWS         = 8,
    parameter int COLS         = 8,
    parameter int PHASE_CYC    = 2,
    parameter int REF_INTERVAL = 32,
    parameter int RETAIN_LIM   = 1024
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req,
    input  logic                                   req_we,
    input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] req_row,
    input  logic [COLS-1:0]                        req_wdata,
    output logic                                   ready,
    output logic                                   rd_valid,
    output logic [COLS-1:0]                        rd_data,
    output logic                                   pre_n,
    output logic [ROWS-1:0]                        row_sel,
    output logic                                   sense_en,
    output logic                                   ref_active,
    output logic                                   cell_err,
    output logic                                   decay_err
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic          ref_pend;
    logic          ref_take;
    logic [RW-1:0] ref_row;
    logic          wr_drive;
    logic [COLS-1:0] wd;

    blm_refresh_sched #(.ROWS(ROWS), .REF_INTERVAL(REF_INTERVAL)) u_sched (
        .clk(clk), .rst_n(rst_n), .take(ref_take), .pend(ref_pend), .row(ref_row)
    );

    blm_sequencer #(.ROWS(ROWS), .COLS(COLS), .PHASE_CYC(PHASE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_row(req_row),
        .req_wdata(req_wdata), .ref_pend(ref_pend), .ref_row(ref_row),
        .ref_take(ref_take), .ready(ready), .pre_n(pre_n), .row_sel(row_sel),
        .sense_en(sense_en), .wr_drive(wr_drive), .wd(wd),
        .ref_active(ref_active), .rd_valid(rd_valid)
    );

    blm_array_model #(.ROWS(ROWS), .COLS(COLS), .RETAIN_LIM(RETAIN_LIM)) u_arr (
        .clk(clk), .rst_n(rst_n), .pre_n(pre_n), .row_sel(row_sel),
        .sense_en(sense_en), .wr_drive(wr_drive), .wd(wd), .sa_out(rd_data),
        .cell_err(cell_err), .decay_err(decay_err)
    );
endmodule

// File: tb/sim_bitline_mem_seq.sv
`timescale 1ns/1ps
module sim_bitline_mem_seq;
    localparam int PH = 2;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [NR];

    // u0: default parameters
    logic       req = 0, req_we = 0;
    logic [2:0] req_row = 0;
    logic [7:0] req_wdata = 0;
    logic       ready, rd_valid, pre_n, sense_en, ref_active, cell_err, decay_err;
    logic [7:0] rd_data, row_sel;

    bitline_mem_seq u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_row(req_row),
        .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .pre_n(pre_n), .row_sel(row_sel), .sense_en(sense_en), .ref_active(ref_active),
        .cell_err(cell_err), .decay_err(decay_err)
    );

    // u1: short retention, refresh effectively never due
    logic       b_req = 0, b_we = 0;
    logic [1:0] b_row = 0;
    logic [7:0] b_wdata = 0;
    logic       b_ready, b_rd_valid, b_pre_n, b_sense_en, b_ref_active, b_cell_err, b_decay_err;
    logic [7:0] b_rd_data;
    logic [3:0] b_row_sel;

    bitline_mem_seq #(.ROWS(4), .COLS(8), .PHASE_CYC(1), .REF_INTERVAL(100000),
                      .RETAIN_LIM(100)) u1 (
        .clk(clk), .rst_n(rst_n), .req(b_req), .req_we(b_we), .req_row(b_row),
        .req_wdata(b_wdata), .ready(b_ready), .rd_valid(b_rd_valid), .rd_data(b_rd_data),
        .pre_n(b_pre_n), .row_sel(b_row_sel), .sense_en(b_sense_en),
        .ref_active(b_ref_active), .cell_err(b_cell_err), .decay_err(b_decay_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Present a u0 request and return just after the accepting edge.
    task automatic u0_issue(input bit we, input int row, input logic [7:0] data);
        @(negedge clk);
        req = 1; req_we = we; req_row = 3'(row); req_wdata = data;
        while (!ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic t_reset_state();
        check(ready == 1'b1, "R1 ready", 32'(ready), 1);
        check(pre_n == 1'b1 && row_sel == 0 && sense_en == 1'b0, "R1 strobes",
              {pre_n, row_sel, sense_en}, {1'b1, 8'h00, 1'b0});
        check(rd_valid == 0 && cell_err == 0 && decay_err == 0, "R1 flags",
              {rd_valid, cell_err, decay_err}, 0);
    endtask

    // R5: write timing and storage into the shadow copy.
    task automatic t_write(input int row, input logic [7:0] data);
        int bad = 0;
        u0_issue(1'b1, row, data);
        for (int k = 1; k <= PH; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req = 0;
                check(ready == 1'b0, "R2 ready low after accept", 32'(ready), 0);
            end
            if (row_sel != 8'(1 << row) || pre_n != 1'b1 || sense_en) bad++;
        end
        @(negedge clk);
        check(bad == 0 && row_sel == 0 && rd_valid == 0, "R5 write phase",
              32'(bad), 0);
        shadow[row] = data;
    endtask

    // R3/R4: per-cycle phase shape, latency and data.
    task automatic t_read(input int row, input string tag);
        int bad = 0;
        u0_issue(1'b0, row, 8'h00);
        for (int k = 1; k <= 3*PH; k++) begin
            @(negedge clk);
            if (k == 1) req = 0;
            if (k <= PH) begin
                if (pre_n != 1'b0 || row_sel != 0 || sense_en) bad++;
            end else if (k <= 2*PH) begin
                if (pre_n != 1'b1 || row_sel != 8'(1 << row) || sense_en) bad++;
            end else begin
                if (pre_n != 1'b1 || row_sel != 8'(1 << row) || !sense_en) bad++;
            end
            if (rd_valid) bad++;
        end
        check(bad == 0, "R3 read phases", 32'(bad), 0);
        @(negedge clk);
        check(rd_valid == 1'b1, "R4 rd_valid latency", 32'(rd_valid), 1);
        check(rd_data == shadow[row], {"R4 ", tag}, 32'(rd_data), 32'(shadow[row]));
        @(negedge clk);
        check(rd_valid == 1'b0, "R4 rd_valid one cycle", 32'(rd_valid), 0);
    endtask

    // R7: hold a read request high; refreshes must still run in row order.
    task automatic t_refresh_priority();
        int nref = 0, order_bad = 0, last_row = -1, nrd = 0;
        bit prev_act = 0, got_row = 0;
        @(negedge clk);
        req = 1; req_we = 0; req_row = 3'd5;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (rd_valid) begin
                nrd++;
                if (rd_data != shadow[5]) order_bad++;
            end
            if (ref_active && !prev_act) begin nref++; got_row = 0; end
            if (ref_active && !got_row && row_sel != 0) begin
                got_row = 1;
                for (int r = 0; r < NR; r++) if (row_sel[r]) begin
                    if (last_row >= 0 && r != (last_row + 1) % NR) order_bad++;
                    last_row = r;
                end
            end
            prev_act = ref_active;
        end
        req = 0;
        check(nref >= 10, "R7 refresh not starved", 32'(nref), 10);
        check(nrd >= 20, "R7 user reads interleaved", 32'(nrd), 20);
        check(order_bad == 0, "R7 refresh row order", 32'(order_bad), 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic u1_access(input bit we, input int row, input logic [7:0] data,
                             output logic [7:0] rdat);
        @(negedge clk);
        b_req = 1; b_we = we; b_row = 2'(row); b_wdata = data;
        while (!b_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        b_req = 0;
        rdat = 8'h00;
        if (!we) begin
            for (int k = 0; k < 10 && !b_rd_valid; k++) @(negedge clk);
            rdat = b_rd_data;
        end
        repeat (2) @(negedge clk);
    endtask

    // R8/R9 on u1: restore before the limit, loss after it.
    task automatic t_decay();
        logic [7:0] d;
        u1_access(1'b1, 2, 8'hA5, d);
        repeat (50) @(negedge clk);
        u1_access(1'b0, 2, 8'h00, d);
        check(d == 8'hA5 && b_decay_err == 0, "R9 read before limit restores",
              {b_decay_err, d}, {1'b0, 8'hA5});
        repeat (60) @(negedge clk);
        check(b_decay_err == 0, "R9 window restarted by sense", 32'(b_decay_err), 0);
        repeat (70) @(negedge clk);
        check(b_decay_err == 1, "R8 decay flag raised", 32'(b_decay_err), 1);
        u1_access(1'b0, 2, 8'h00, d);
        check(d == 8'h00, "R8 decayed row reads zero", 32'(d), 0);
        check(b_cell_err == 0, "R6 no cell error on u1", 32'(b_cell_err), 0);
    endtask

    initial begin
        for (int r = 0; r < NR; r++) shadow[r] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_read(4, "unwritten row reads zero");
        t_write(0, 8'h5A);
        t_write(7, 8'hFF);
        t_write(3, 8'h81);
        t_write(5, 8'h3C);
        t_read(0, "row 0 data");
        t_read(7, "row 7 all ones");
        t_read(3, "row 3 data");
        t_write(3, 8'h00);
        t_read(3, "row 3 overwritten zeros");
        t_read(5, "row 5 first read");
        t_read(5, "R9 row 5 repeated read");
        t_refresh_priority();
        repeat (600) @(negedge clk);
        t_read(0, "R9 row 0 after many refreshes");
        t_read(7, "R9 row 7 after many refreshes");
        check(cell_err == 0, "R6 cell_err stays low", 32'(cell_err), 0);
        check(decay_err == 0, "R8 refresh prevents decay", 32'(decay_err), 0);
        t_decay();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule